// File: doc/BRIEF.md
# Dual-Mode Sine and Square-Wave Sample Engine

This block produces one 8-bit unsigned code for a parallel digital-to-analog converter. A 6-bit phase index steps through a cycle of 64 positions. It moves one step on each single-cycle sample tick from an external rate source. The code goes out on every clock, with no write strobe, so the converter can follow the bus continuously.

A mode input chooses between two outputs. The first is a sine taken from a computed 64-point table. The second is a square wave that swings between the two ends of the code range. Its high time is picked by a 3-bit duty preset in steps of 8 phase positions out of 64. Both outputs read the same phase counter, so switching mode never restarts the cycle.

The output code is registered. Between ticks it holds its value, so a mode or duty change reaches the output only at the next tick.

Top module: `wg_dual_engine`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the phase index becomes 0 and `dac_q` becomes 128 if `mode` is 0 or 0 if `mode` is 1.
- R2: The phase index advances by one only at an edge where `tick` is 1 and wraps from 63 to 0; at an edge with `tick` at 0 both the phase and `dac_q` hold.
- R3: At an edge with `tick` at 1, `dac_q` loads the code of the new (incremented) phase, computed from `mode` and `duty` as sampled at that same edge.
- R4: The sine code for phase k < 32 is round(127.5 + 127.5·sin(2πk/64)) with halves rounded up; for k ≥ 32 it is 255 minus the code of k−32. Thus k=0 gives 128, k=16 gives 255, k=32 gives 127 and k=48 gives 0.
- R5: In square-wave mode, `dac_q` is 0xFF when the phase is less than `duty`×8 (`duty` read as an unsigned 3-bit number) and 0x00 otherwise.
- R6: With `duty` equal to 0, the square-wave output is 0x00 at every phase.
- R7: `mode` 0 selects the sine code and `mode` 1 selects the square-wave code.
- R8: A change of `mode` or `duty` does not reset or move the phase, and it does not alter `dac_q` until the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Sample strobe, one clock wide |
| mode | input | 1 | 0 = sine, 1 = square wave |
| duty | input | 3 | Square-wave high time in eighths of the cycle |
| dac_q | output | 8 | Registered converter code |

## Verification
Two functions meet at a tick: the phase step and the reload of the output code. The reload must use the phase after the step, together with `mode` and `duty` as they stand at that very edge. The bench forces the collision by changing mode and duty in the same cycle as a tick, both in directed sequences and in random ones. It judges the result against a reference model that advances its own phase first and then computes the code from the inputs of that edge. Mode and duty changes in cycles without a tick are checked to leave the output unchanged.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int PH_W   = 6;
  localparam int CODE_W = 8;
  localparam int DUTY_W = 3;
  localparam int STEPS  = 1 << PH_W;
  localparam int DUTY_SHIFT = PH_W - DUTY_W;

  typedef enum logic {WG_SINE = 1'b0, WG_SQUARE = 1'b1} wg_mode_e;

  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;
  localparam logic [CODE_W-1:0] CODE_MID = 8'd128;

  // first quarter of the wave, positions 0..15 (position 16 is the peak)
  function automatic logic [CODE_W-1:0] quarter_code(input logic [3:0] i);
    case (i)
      4'd0:  return 8'd128;
      4'd1:  return 8'd140;
      4'd2:  return 8'd152;
      4'd3:  return 8'd165;
      4'd4:  return 8'd176;
      4'd5:  return 8'd188;
      4'd6:  return 8'd198;
      4'd7:  return 8'd208;
      4'd8:  return 8'd218;
      4'd9:  return 8'd226;
      4'd10: return 8'd234;
      4'd11: return 8'd240;
      4'd12: return 8'd245;
      4'd13: return 8'd250;
      4'd14: return 8'd253;
      default: return 8'd254;
    endcase
  endfunction

  // positive half by folding the quarter, negative half by complement
  function automatic logic [CODE_W-1:0] sine_code(input logic [PH_W-1:0] k);
    logic [CODE_W-1:0] half;
    if (!k[4])              half = quarter_code(k[3:0]);
    else if (k[3:0] == 4'd0) half = CODE_MAX;
    else                    half = quarter_code(4'(5'd16 - {1'b0, k[3:0]}));
    return k[5] ? (CODE_MAX - half) : half;
  endfunction

  function automatic logic [CODE_W-1:0] square_code(input logic [PH_W-1:0] k,
                                                    input logic [DUTY_W-1:0] d);
    logic [PH_W-1:0] edge_pos;
    edge_pos = PH_W'({d, {DUTY_SHIFT{1'b0}}});
    return (k < edge_pos) ? CODE_MAX : CODE_MIN;
  endfunction
endpackage

// File: rtl/wg_phase_ctr.sv
module wg_phase_ctr #(
  parameter int PH_W = wg_pkg::PH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  output logic [PH_W-1:0] phase_q,
  output logic [PH_W-1:0] phase_nx
);
  assign phase_nx = phase_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= '0;
    else if (step) phase_q <= phase_nx;
  end
endmodule

// File: rtl/wg_sine_rom.sv
module wg_sine_rom #(
  parameter int PH_W   = wg_pkg::PH_W,
  parameter int CODE_W = wg_pkg::CODE_W
) (
  input  logic [PH_W-1:0]   idx,
  output logic [CODE_W-1:0] code
);
  always_comb code = wg_pkg::sine_code(idx);
endmodule

// File: rtl/wg_square_cmp.sv
module wg_square_cmp #(
  parameter int PH_W   = wg_pkg::PH_W,
  parameter int DUTY_W = wg_pkg::DUTY_W,
  parameter int CODE_W = wg_pkg::CODE_W
) (
  input  logic [PH_W-1:0]   idx,
  input  logic [DUTY_W-1:0] duty,
  output logic [CODE_W-1:0] code
);
  always_comb code = wg_pkg::square_code(idx, duty);
endmodule

// File: rtl/wg_dual_engine.sv
module wg_dual_engine
  import wg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mode,
  input  logic [DUTY_W-1:0] duty,
  output logic [CODE_W-1:0] dac_q
);
  logic [PH_W-1:0]   phase_q;
  logic [PH_W-1:0]   phase_nx;
  logic [CODE_W-1:0] sine_c;
  logic [CODE_W-1:0] square_c;
  logic [CODE_W-1:0] sel_c;
  logic [CODE_W-1:0] rst_c;

  wg_phase_ctr #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .step(tick),
    .phase_q(phase_q), .phase_nx(phase_nx)
  );

  wg_sine_rom #(.PH_W(PH_W), .CODE_W(CODE_W)) u_sine (
    .idx(phase_nx), .code(sine_c)
  );

  wg_square_cmp #(.PH_W(PH_W), .DUTY_W(DUTY_W), .CODE_W(CODE_W)) u_square (
    .idx(phase_nx), .duty(duty), .code(square_c)
  );

  always_comb begin
    sel_c = (wg_mode_e'(mode) == WG_SQUARE) ? square_c : sine_c;
    rst_c = (wg_mode_e'(mode) == WG_SQUARE) ? CODE_MIN : CODE_MID;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    dac_q <= rst_c;
    else if (tick) dac_q <= sel_c;
  end
endmodule

// File: rtl/wg_dual_engine_chk.sv
module wg_dual_engine_chk
  import wg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              mode,
  input logic [DUTY_W-1:0] duty,
  input logic [PH_W-1:0]   phase_q,
  input logic [CODE_W-1:0] dac_q
);
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dac_q));

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase_q == PH_W'($past(phase_q) + 1'b1));

  p_square_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode) |=> (dac_q == CODE_MAX || dac_q == CODE_MIN));

  p_duty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode && duty == '0) |=> dac_q == CODE_MIN);

  p_sine_peak_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !mode && phase_q == PH_W'(15)) |=> dac_q == CODE_MAX);

  p_sine_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !mode && phase_q == PH_W'(47)) |=> dac_q == CODE_MIN);
endmodule

bind wg_dual_engine wg_dual_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
  .duty(duty), .phase_q(phase_q), .dac_q(dac_q)
);

// File: tb/test_wg_dual_engine.sv
module test_wg_dual_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       mode = 1'b0;
  logic [2:0] duty = 3'd0;
  logic [7:0] dac_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int ph = 0;
  logic [7:0] exp_q = 8'd128;

  always #2 clk = ~clk;

  wg_dual_engine i_wg_dual_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
    .duty(duty), .dac_q(dac_q)
  );

  function automatic int ref_sine(input int k);
    real r;
    if (k >= 32) return 255 - ref_sine(k - 32);
    r = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * k / 64.0);
    return $rtoi(r + 0.5);
  endfunction

  function automatic logic [7:0] ref_code(input int k, input logic m, input logic [2:0] d);
    if (!m) return 8'(ref_sine(k));
    return (k < int'(d) * 8) ? 8'hFF : 8'h00;
  endfunction

  task automatic step(input logic t, input logic m, input logic [2:0] d, input string tag);
    tick = t; mode = m; duty = d;
    @(posedge clk);
    if (!rst_n) begin
      ph = 0;
      exp_q = m ? 8'h00 : 8'd128;
    end else if (t) begin
      ph = (ph + 1) % 64;
      exp_q = ref_code(ph, m, d);
    end
    @(negedge clk);
    checks++;
    if (dac_q !== exp_q) begin
      errors++;
      $display("FAIL %s: phase %0d mode %0b duty %0d dac_q=%0d expected %0d",
               tag, ph, m, d, dac_q, exp_q);
    end
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0;
    step(1'b1, m, 3'd5, "R1");
    step(1'b0, m, 3'd5, "R1");
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);

    // R1: reset value tracks the mode input
    do_reset(1'b0);
    do_reset(1'b1);
    do_reset(1'b0);

    // R4 R2: full sine cycle including wrap 63 -> 0
    for (int i = 0; i < 66; i++) step(1'b1, 1'b0, 3'd0, "R4");

    // R8 R2: mode and duty wiggle with no tick, output must hold
    for (int i = 0; i < 8; i++) step(1'b0, i[0], 3'(i), "R8");

    // R5 R6: every duty preset over a full cycle
    for (int d = 0; d < 8; d++)
      for (int i = 0; i < 64; i++)
        step(1'b1, 1'b1, 3'(d), (d == 0) ? "R6" : "R5");

    // R7 R3: mode flips at the same edge as the tick
    for (int i = 0; i < 40; i++) step(1'b1, i[1], 3'd3, "R7");

    // R3 R8: random ticks, modes and duties
    for (int i = 0; i < 3000; i++)
      step(1'($urandom() % 2), 1'($urandom() % 2), 3'($urandom() % 8), "R3");

    // R1: reset in the middle of a run
    do_reset(1'b1);
    step(1'b1, 1'b1, 3'd7, "R5");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule